// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block merges the interrupt sources of a serial port into one active-high interrupt line and a 4-bit identification code for the CPU. It receives event pulses and levels from the receiver, the transmitter and the modem-line logic. It keeps a latched flag for each source that needs one. It masks the sources with a 4-bit enable register and reports only the most urgent source that is both pending and enabled.

The block also applies the side effects of CPU accesses. Reading the line status clears the line-status interrupt. Reading receive data clears the character timeout. Reading the modem status clears the modem interrupt. Writing the transmit holding register clears the transmit-empty interrupt. Reading the identification code also clears the transmit-empty interrupt, but only while that interrupt is the one being reported. The receive data-ready interrupt is not latched: it follows the receive FIFO level and the trigger level. The character timeout comes from a small counter of character times.

Every flag and the enable register are updated on a clock edge. The interrupt line and the identification code follow from them without further delay, so they change in the cycle after the edge that captured the stimulus.

Top module: `uart_irq_ctrl`

## Requirements
- R1: At most one source is reported at a time, in this fixed order of precedence: line status first, then the receive level (a character timeout is shown in preference to data ready), then transmit empty, then modem status last.
- R2: The identification code has bit 0 equal to 1 when nothing is reported. Otherwise bits 3:0 are 0110 for line status, 0100 for data ready, 1100 for character timeout, 0010 for transmit empty and 0000 for modem status.
- R3: A write strobe loads the enable register. Bit 0 enables receive data ready and timeout, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status. A masked source affects neither the interrupt line nor the code, but its latched flag is kept.
- R4: After reset the enable register is zero, no flag is set, the interrupt line is low and the code is 0001.
- R5: A line-error pulse sets the line-status flag and a line-status read clears it. When both fall in the same cycle, the flag stays set. An identification read leaves this flag unchanged.
- R6: Data ready is pending while the receive level is non-zero and at least the trigger level. It is not latched.
- R7: A rising edge of the holding-empty input sets the transmit-empty flag. A holding-register write clears it. An identification read clears it only while transmit empty is the reported source. A level that stays high does not set the flag again.
- R8: The character timeout becomes pending after TMO_CHARS character-time pulses during which the receive level is non-zero and no character was received or read. A receive-data read clears it, and a received character restarts the count.
- R9: The interrupt line is high exactly when some enabled source is pending, which is when bit 0 of the code is 0.
- R10: A modem-change pulse sets the modem flag and a modem-status read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| ls_evt | input | 1 | Receiver line error event pulse |
| lsr_rd | input | 1 | Line status read strobe |
| rx_level | input | LVL_W (5) | Receive FIFO fill level |
| rx_trig | input | LVL_W (5) | Receive trigger level |
| rx_char_done | input | 1 | Character received pulse |
| rbr_rd | input | 1 | Receive data read strobe |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification read strobe |
| ms_evt | input | 1 | Modem line change pulse |
| msr_rd | input | 1 | Modem status read strobe |
| irq | output | 1 | Interrupt request, active high |
| iir_id | output | 4 | Identification code |

## Verification
A source can be set and cleared in the same cycle. The line-error pulse and the line-status read are driven in one cycle while line status is the reported source, and the code must still read 0110 on the next cycle. A further read alone must then bring it to 0001. A second collision puts a rising holding-empty edge in the same cycle as a pending line error, followed by an identification read. The code must stay at 0110 because transmit empty was not the reported source, and it must drop to 0010 once the line status is read. The remaining cases are covered by a vector table of enable masks, events and FIFO levels, and by directed sequences for the timeout counter.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants for the UART interrupt controller.
// Assumes a 4-bit enable register and a 4-bit identification code.
package uart_irq_pkg;

    // Positions of the enable bits
    localparam int EN_RX   = 0;
    localparam int EN_THRE = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;

    // Identification codes (bit 0 = 1 means nothing pending)
    localparam logic [3:0] ID_NONE = 4'b0001;
    localparam logic [3:0] ID_LS   = 4'b0110;
    localparam logic [3:0] ID_RDA  = 4'b0100;
    localparam logic [3:0] ID_TMO  = 4'b1100;
    localparam logic [3:0] ID_THRE = 4'b0010;
    localparam logic [3:0] ID_MS   = 4'b0000;

    // Index of each source in the grant vector
    localparam int G_LS   = 0;
    localparam int G_TMO  = 1;
    localparam int G_RDA  = 2;
    localparam int G_THRE = 3;
    localparam int G_MS   = 4;
    localparam int NSRC   = 5;

endpackage

// File: rtl/uart_irq_tmo.sv
// Character timeout counter. It counts character-time pulses while the
// receive FIFO holds data. A received character, a receive read or an
// empty FIFO restarts the count. The count saturates at TMO_CHARS.
// Assumes char_tick is a single-cycle pulse per character time.
module uart_irq_tmo #(
    parameter int LVL_W     = 5,
    parameter int TMO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_char_done,
    input  logic             rbr_rd,
    input  logic             char_tick,
    output logic             tmo_hit
);
    localparam int CW = $clog2(TMO_CHARS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CHARS);

    logic [CW-1:0] cnt;

    // Count idle character times; restart on any receive activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (rx_char_done || rbr_rd || (rx_level == '0)) begin
            cnt <= '0;
        end else if (char_tick && (cnt != LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Timeout is pending once the full idle window has elapsed
    always_comb begin
        tmo_hit = (cnt == LIMIT);
    end

endmodule

// File: rtl/uart_irq_srcs.sv
// Latched interrupt sources: line status, transmit empty and modem
// status, each with its own set and clear rule. When a set and a clear
// fall in the same cycle, the set wins.
// Assumes thre_shown comes from the priority logic of the same cycle.
module uart_irq_srcs (
    input  logic clk,
    input  logic rst_n,
    input  logic ls_evt,
    input  logic lsr_rd,
    input  logic thr_empty,
    input  logic thr_wr,
    input  logic iir_rd,
    input  logic thre_shown,
    input  logic ms_evt,
    input  logic msr_rd,
    output logic ls_flag,
    output logic thre_flag,
    output logic ms_flag
);
    logic thr_prev;
    logic thr_rise;

    // Detect the rising edge of the holding-empty level
    always_comb begin
        thr_rise = thr_empty && !thr_prev;
    end

    // Remember the previous holding-empty level (reset high: no edge after reset)
    always_ff @(posedge clk) begin
        if (!rst_n) thr_prev <= 1'b1;
        else        thr_prev <= thr_empty;
    end

    // Line-status flag: set by an error event, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n)      ls_flag <= 1'b0;
        else if (ls_evt) ls_flag <= 1'b1;
        else if (lsr_rd) ls_flag <= 1'b0;
    end

    // Transmit-empty flag: set on an edge, cleared by a write or a reported read
    always_ff @(posedge clk) begin
        if (!rst_n)                            thre_flag <= 1'b0;
        else if (thr_rise)                     thre_flag <= 1'b1;
        else if (thr_wr || (iir_rd && thre_shown)) thre_flag <= 1'b0;
    end

    // Modem flag: set by a line change, cleared by a modem-status read
    always_ff @(posedge clk) begin
        if (!rst_n)      ms_flag <= 1'b0;
        else if (ms_evt) ms_flag <= 1'b1;
        else if (msr_rd) ms_flag <= 1'b0;
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority selector. It masks the pending sources with the enable
// register, grants the most urgent one and encodes the identification
// code. Purely combinational.
// Assumes the grant vector is ordered from highest to lowest priority.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic            ls_flag,
    input  logic            tmo_hit,
    input  logic            rda_lvl,
    input  logic            thre_flag,
    input  logic            ms_flag,
    input  logic [3:0]      ier_q,
    output logic [NSRC-1:0] grant,
    output logic            irq,
    output logic [3:0]      iir_id
);
    logic [NSRC-1:0] req;

    // Apply the enable mask to each source
    always_comb begin
        req          = '0;
        req[G_LS]    = ls_flag   && ier_q[EN_LS];
        req[G_TMO]   = tmo_hit   && ier_q[EN_RX];
        req[G_RDA]   = rda_lvl   && ier_q[EN_RX];
        req[G_THRE]  = thre_flag && ier_q[EN_THRE];
        req[G_MS]    = ms_flag   && ier_q[EN_MS];
    end

    // Grant the lowest-index request; higher indices are masked
    always_comb begin
        grant = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) grant = NSRC'(1) << i;
        end
    end

    // Interrupt line is the OR of all masked requests
    always_comb begin
        irq = |req;
    end

    // Encode the granted source
    always_comb begin
        unique case (1'b1)
            grant[G_LS]:   iir_id = ID_LS;
            grant[G_TMO]:  iir_id = ID_TMO;
            grant[G_RDA]:  iir_id = ID_RDA;
            grant[G_THRE]: iir_id = ID_THRE;
            grant[G_MS]:   iir_id = ID_MS;
            default:       iir_id = ID_NONE;
        endcase
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
// Top of the UART interrupt controller. It holds the enable register,
// derives the data-ready level, and connects the timeout counter, the
// latched sources and the priority selector.
// Assumes every strobe and event input is a single-cycle pulse on clk.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TMO_CHARS  = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [3:0]       ier_wdata,
    input  logic             ls_evt,
    input  logic             lsr_rd,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_char_done,
    input  logic             rbr_rd,
    input  logic             char_tick,
    input  logic             thr_empty,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             ms_evt,
    input  logic             msr_rd,
    output logic             irq,
    output logic [3:0]       iir_id
);
    logic [3:0]      ier_q;
    logic            rda_lvl;
    logic            tmo_hit;
    logic            ls_flag;
    logic            thre_flag;
    logic            ms_flag;
    logic [NSRC-1:0] grant;

    // Enable register, loaded by the CPU write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      ier_q <= '0;
        else if (ier_wr) ier_q <= ier_wdata;
    end

    // Data ready follows the FIFO level against the trigger
    always_comb begin
        rda_lvl = (rx_level != '0) && (rx_level >= rx_trig);
    end

    uart_irq_tmo #(
        .LVL_W     (LVL_W),
        .TMO_CHARS (TMO_CHARS)
    ) tmo_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_level     (rx_level),
        .rx_char_done (rx_char_done),
        .rbr_rd       (rbr_rd),
        .char_tick    (char_tick),
        .tmo_hit      (tmo_hit)
    );

    uart_irq_srcs srcs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ls_evt     (ls_evt),
        .lsr_rd     (lsr_rd),
        .thr_empty  (thr_empty),
        .thr_wr     (thr_wr),
        .iir_rd     (iir_rd),
        .thre_shown (grant[G_THRE]),
        .ms_evt     (ms_evt),
        .msr_rd     (msr_rd),
        .ls_flag    (ls_flag),
        .thre_flag  (thre_flag),
        .ms_flag    (ms_flag)
    );

    uart_irq_prio prio_i (
        .ls_flag   (ls_flag),
        .tmo_hit   (tmo_hit),
        .rda_lvl   (rda_lvl),
        .thre_flag (thre_flag),
        .ms_flag   (ms_flag),
        .ier_q     (ier_q),
        .grant     (grant),
        .irq       (irq),
        .iir_id    (iir_id)
    );

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Checker for the UART interrupt controller, bound to the top module.
// Assumes it sees the top's ports and a few internal nets by name.
module uart_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_wr,
    input logic [3:0] ier_wdata,
    input logic [3:0] ier_q,
    input logic       ls_evt,
    input logic       thr_wr,
    input logic       thr_empty,
    input logic       thre_flag,
    input logic       ms_evt,
    input logic       msr_rd,
    input logic       ms_flag,
    input logic       rbr_rd,
    input logic       tmo_hit,
    input logic [4:0] grant,
    input logic       irq,
    input logic [3:0] iir_id
);

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9
    irq_id_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir_id[0]);

    // R5
    ls_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_evt && !ier_wr && ier_q[2] |=> iir_id == 4'b0110);

    // R3
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr && (ier_wdata == 4'b0000) |=> !irq && iir_id == 4'b0001);

    // R7
    thr_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr && !thr_empty |=> !thre_flag);

    // R10
    msr_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msr_rd && !ms_evt |=> !ms_flag);

    // R8
    rx_read_clears_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rbr_rd |=> !tmo_hit);

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_wr    (ier_wr),
    .ier_wdata (ier_wdata),
    .ier_q     (ier_q),
    .ls_evt    (ls_evt),
    .thr_wr    (thr_wr),
    .thr_empty (thr_empty),
    .thre_flag (thre_flag),
    .ms_evt    (ms_evt),
    .msr_rd    (msr_rd),
    .ms_flag   (ms_flag),
    .rbr_rd    (rbr_rd),
    .tmo_hit   (tmo_hit),
    .grant     (grant),
    .irq       (irq),
    .iir_id    (iir_id)
);

// File: tb/uart_irq_ctrl_tb_top.sv
// Self-checking bench for the UART interrupt controller: a vector table
// first, then directed sequences for reset and corner cases.
module uart_irq_ctrl_tb_top;

    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ier_wr = 1'b0;
    logic [3:0]       ier_wdata = '0;
    logic             ls_evt = 1'b0;
    logic             lsr_rd = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] rx_trig = '0;
    logic             rx_char_done = 1'b0;
    logic             rbr_rd = 1'b0;
    logic             char_tick = 1'b0;
    logic             thr_empty = 1'b0;
    logic             thr_wr = 1'b0;
    logic             iir_rd = 1'b0;
    logic             ms_evt = 1'b0;
    logic             msr_rd = 1'b0;
    logic             irq;
    logic [3:0]       iir_id;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ls_evt(ls_evt), .lsr_rd(lsr_rd), .rx_level(rx_level), .rx_trig(rx_trig),
        .rx_char_done(rx_char_done), .rbr_rd(rbr_rd), .char_tick(char_tick),
        .thr_empty(thr_empty), .thr_wr(thr_wr), .iir_rd(iir_rd),
        .ms_evt(ms_evt), .msr_rd(msr_rd), .irq(irq), .iir_id(iir_id)
    );

    // Vector: {ier[3:0], ls, ms, level[4:0], trig[4:0], expected id[3:0]}
    localparam logic [19:0] VEC [0:10] = '{
        {4'hF, 1'b1, 1'b1, 5'd4,  5'd2, 4'b0110},
        {4'hB, 1'b1, 1'b1, 5'd4,  5'd2, 4'b0100},
        {4'h9, 1'b1, 1'b1, 5'd1,  5'd2, 4'b0000},
        {4'h8, 1'b0, 1'b1, 5'd0,  5'd0, 4'b0000},
        {4'h0, 1'b1, 1'b1, 5'd8,  5'd1, 4'b0001},
        {4'h4, 1'b1, 1'b0, 5'd0,  5'd0, 4'b0110},
        {4'h1, 1'b0, 1'b0, 5'd2,  5'd2, 4'b0100},
        {4'h1, 1'b0, 1'b0, 5'd0,  5'd0, 4'b0001},
        {4'h7, 1'b0, 1'b1, 5'd16, 5'd8, 4'b0100},
        {4'hE, 1'b0, 1'b1, 5'd16, 5'd1, 4'b0000},
        {4'h4, 1'b1, 1'b1, 5'd16, 5'd1, 4'b0110}
    };

    // One clock: inputs set at a falling edge, outputs read at the next one
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        ier_wr = 1'b0; ls_evt = 1'b0; lsr_rd = 1'b0; rx_char_done = 1'b0;
        rbr_rd = 1'b0; thr_wr = 1'b0; iir_rd = 1'b0; ms_evt = 1'b0; msr_rd = 1'b0;
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [3:0] exp_id);
        check(req, iir_id, exp_id);
        check({req, " irq"}, {3'b0, irq}, {3'b0, !exp_id[0]});
    endtask

    task automatic set_ier(input logic [3:0] v);
        ier_wr = 1'b1; ier_wdata = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        check_out("R4 reset", 4'b0001);
        rst_n = 1'b1;
        tick();
        check_out("R4 after release", 4'b0001);

        // R1 R2 R3 R6: vector table
        for (int i = 0; i < 11; i++) begin
            set_ier(VEC[i][19:16]);
            ls_evt   = VEC[i][15];
            ms_evt   = VEC[i][14];
            rx_level = VEC[i][13:9];
            rx_trig  = VEC[i][8:4];
            tick();
            check_out($sformatf("R1 R2 R3 R6 vector %0d", i), VEC[i][3:0]);
            lsr_rd = 1'b1; msr_rd = 1'b1; rx_level = '0;
            tick();
        end

        // R7: transmit empty edge, reported read, write
        set_ier(4'h2); thr_empty = 1'b0; tick();
        thr_empty = 1'b1; tick();
        check_out("R7 rise sets", 4'b0010);
        iir_rd = 1'b1; tick();
        check_out("R7 reported read clears", 4'b0001);
        tick();
        check_out("R7 steady level no re-arm", 4'b0001);
        thr_empty = 1'b0; tick();
        thr_empty = 1'b1; tick();
        check_out("R7 second rise", 4'b0010);
        thr_wr = 1'b1; thr_empty = 1'b0; tick();
        check_out("R7 write clears", 4'b0001);

        // R5 R7 R1: identification read while line status outranks transmit empty
        set_ier(4'h6); ls_evt = 1'b1; thr_empty = 1'b1; tick();
        check_out("R1 line status over transmit empty", 4'b0110);
        iir_rd = 1'b1; tick();
        check_out("R5 id read keeps line status", 4'b0110);
        lsr_rd = 1'b1; tick();
        check_out("R7 unreported read kept transmit empty", 4'b0010);
        iir_rd = 1'b1; thr_empty = 1'b0; tick();
        check_out("R7 now reported, read clears", 4'b0001);

        // R5: set and clear in the same cycle
        set_ier(4'h4); ls_evt = 1'b1; tick();
        check_out("R5 event sets", 4'b0110);
        ls_evt = 1'b1; lsr_rd = 1'b1; tick();
        check_out("R5 set wins over read", 4'b0110);
        lsr_rd = 1'b1; tick();
        check_out("R5 read clears", 4'b0001);

        // R8: character timeout
        set_ier(4'h1); rx_level = 5'd1; rx_trig = 5'd4; char_tick = 1'b1;
        tick(); tick(); tick();
        check_out("R8 three idle chars", 4'b0001);
        tick();
        check_out("R8 four idle chars", 4'b1100);
        char_tick = 1'b0; rx_char_done = 1'b1; tick();
        check_out("R8 received char restarts", 4'b0001);
        char_tick = 1'b1; tick(); tick(); tick();
        check_out("R8 restart window not yet full", 4'b0001);
        tick();
        check_out("R8 timeout again", 4'b1100);
        char_tick = 1'b0; rx_trig = 5'd1; tick();
        check_out("R1 timeout over data ready", 4'b1100);
        rbr_rd = 1'b1; tick();
        check_out("R8 read clears timeout, R6 data ready remains", 4'b0100);
        rx_level = '0; tick();
        check_out("R6 empty FIFO", 4'b0001);

        // R10: modem status
        set_ier(4'h8); ms_evt = 1'b1; tick();
        check_out("R10 change sets", 4'b0000);
        iir_rd = 1'b1; tick();
        check_out("R10 id read keeps", 4'b0000);
        msr_rd = 1'b1; tick();
        check_out("R10 read clears", 4'b0001);

        // R3 R9: masking keeps the latched flag
        set_ier(4'hF); ms_evt = 1'b1; tick();
        check_out("R9 enabled modem", 4'b0000);
        set_ier(4'h0); tick();
        check_out("R3 all masked", 4'b0001);
        set_ier(4'h8); tick();
        check_out("R3 flag kept while masked", 4'b0000);
        msr_rd = 1'b1; tick();
        check_out("R10 final clear", 4'b0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule